// File: doc/BRIEF.md
# Iterative Word Divider

This block computes the quotient of two machine words for an integer execution unit. A request is presented with a one-cycle `start` strobe together with the dividend, the divisor, and three per-operation controls. The first selects two's-complement or unsigned interpretation. The second requests an overflow flag update. The third requests a condition-field update.

Legal divisions run through a restoring shift-subtract loop on operand magnitudes, producing one quotient bit per clock. The quotient is negated at the end when the operand signs differ. Illegal divisions are caught when the request is accepted and finish on the next clock without iterating. These are a zero divisor, or a signed division of the most negative word by minus one. Each produces a fixed architectural result instead of an arbitrary one.

The result and the flag strobes are valid for the single cycle in which `done` is high. The quotient and the condition field then hold until the next completion. The caller supplies the current summary-overflow state on `so_in`, so that the condition field can carry it.

Top module: `word_divider`

## Requirements
- R1: An unsigned legal division returns floor(dividend / divisor). `busy` rises the cycle after the accepting edge and stays high for exactly WIDTH cycles. `done` is high in the cycle after the last of these, with `busy` low.
- R2: A signed legal division treats both operands as two's complement and returns the quotient truncated toward zero, for example -7/2 = -3 and -7/-2 = 3. An unsigned division of 0x80000000 by 0xFFFFFFFF is legal and returns 0.
- R3: A zero divisor is illegal. For unsigned operation the quotient is 0. For signed operation every quotient bit equals the dividend's top bit.
- R4: A signed division of 0x80000000 by 0xFFFFFFFF is illegal and returns 0.
- R5: An illegal division raises `done` in the cycle right after the accepting edge, and `busy` never rises for it.
- R6: `ov_wr` pulses with `done` exactly when the overflow enable was set at acceptance. When it pulses, `ov_val` is 1 for an illegal division and 0 for a legal one.
- R7: `so_set` pulses with `done` only when the overflow enable was set and the division was illegal, and it is never used to clear the summary flag.
- R8: `cr0_wr` pulses with `done` exactly when the record enable was set. `cr0` is {lt, gt, eq, so}: bit 3 means the quotient is negative as a signed word, bit 2 means it is positive, and bit 1 means it is zero. Bit 0 is `so_in` OR'd with this operation's `so_set`.
- R9: `done` lasts one cycle per accepted request. A `start` raised while `busy` is high is ignored, and the operands driven with it do not alter the running division. A `start` in the completion cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| signed_op | input | 1 | 1 = two's-complement operands |
| ovf_en | input | 1 | Request overflow flag update |
| rec_en | input | 1 | Request condition field update |
| so_in | input | 1 | Current summary-overflow state |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | WIDTH | Result, held after completion |
| ov_wr | output | 1 | Overflow flag write strobe |
| ov_val | output | 1 | Overflow flag value |
| so_set | output | 1 | Summary-overflow set strobe |
| cr0_wr | output | 1 | Condition field write strobe |
| cr0 | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
The bench goes after the corners where a divider most easily goes wrong.

- **Signed zero divisor.** A design that always returns 0 here shows up when the dividend is negative.
- **Most negative word divided by minus one.** A design that lets this case iterate returns 0x80000000 with no overflow.
- **Same operands as unsigned.** A design that marks this case illegal reports a false overflow.
- **Mixed-sign truncation.** A design that floors instead of truncating is off by one on inexact quotients.

It also holds `start` high during a running division, with other operands on the inputs. A design that re-accepts the request shows an early `done` or a corrupted quotient. It issues back-to-back illegal requests to confirm that each one gets its own one-cycle completion.

// File: rtl/word_div_pkg.sv
package word_div_pkg;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } div_cond_t;

endpackage

// File: rtl/div_screen.sv
module div_screen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  input  logic             is_signed,
  output logic             bad_div,
  output logic [WIDTH-1:0] bad_quo,
  output logic [WIDTH-1:0] num_mag,
  output logic [WIDTH-1:0] den_mag,
  output logic             flip_sign
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] f_mag(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic f_illegal(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                     input logic sgn);
    return (b == '0) || (sgn && a == MOST_NEG && b == ALL_ONES);
  endfunction

  always_comb begin
    bad_div   = f_illegal(num, den, is_signed);
    bad_quo   = (is_signed && den == '0) ? {WIDTH{num[WIDTH-1]}} : '0;
    num_mag   = f_mag(num, is_signed);
    den_mag   = f_mag(den, is_signed);
    flip_sign = is_signed && (num[WIDTH-1] ^ den[WIDTH-1]);
  end
endmodule

// File: rtl/div_restore.sv
module div_restore #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] num_mag,
  input  logic [WIDTH-1:0] den_mag,
  output logic             running,
  output logic             final_step,
  output logic [WIDTH-1:0] quo_next
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] part_rem, shreg, den_r;
  logic [CW-1:0]    step_cnt;
  logic [WIDTH-1:0] rem_next;

  function automatic logic [2*WIDTH-1:0] f_step(input logic [WIDTH-1:0] r,
                                               input logic [WIDTH-1:0] q,
                                               input logic [WIDTH-1:0] d);
    logic [WIDTH:0] trial;
    trial = {r, q[WIDTH-1]} - {1'b0, d};
    if (!trial[WIDTH])
      return {trial[WIDTH-1:0], q[WIDTH-2:0], 1'b1};
    else
      return {r[WIDTH-2:0], q[WIDTH-1], q[WIDTH-2:0], 1'b0};
  endfunction

  always_comb begin
    {rem_next, quo_next} = f_step(part_rem, shreg, den_r);
    final_step           = running && (step_cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      step_cnt <= '0;
      part_rem <= '0;
      shreg    <= '0;
      den_r    <= '0;
    end else if (load) begin
      running  <= 1'b1;
      step_cnt <= '0;
      part_rem <= '0;
      shreg    <= num_mag;
      den_r    <= den_mag;
    end else if (running) begin
      part_rem <= rem_next;
      shreg    <= quo_next;
      step_cnt <= step_cnt + 1'b1;
      if (final_step) running <= 1'b0;
    end
  end

  assert_step_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (step_cnt < CW'(WIDTH)));
  assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !running);
endmodule

// File: rtl/word_divider.sv
module word_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             signed_op,
  input  logic             ovf_en,
  input  logic             rec_en,
  input  logic             so_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic             ov_wr,
  output logic             ov_val,
  output logic             so_set,
  output logic             cr0_wr,
  output logic [3:0]       cr0
);
  import word_div_pkg::*;

  logic             accept, accept_bad, accept_good;
  logic             bad_div, flip_sign;
  logic [WIDTH-1:0] bad_quo, num_mag, den_mag, quo_next;
  logic             running, final_step;
  logic             neg_l, ovf_l, rec_l;
  div_cond_t        cond_q;

  function automatic logic [WIDTH-1:0] f_apply_sign(input logic [WIDTH-1:0] m, input logic neg);
    return neg ? (~m + 1'b1) : m;
  endfunction

  function automatic div_cond_t f_cond(input logic [WIDTH-1:0] q);
    div_cond_t c;
    c.lt = q[WIDTH-1];
    c.eq = (q == '0);
    c.gt = !q[WIDTH-1] && (q != '0);
    return c;
  endfunction

  div_screen #(.WIDTH(WIDTH)) u_screen (
    .num(dividend), .den(divisor), .is_signed(signed_op),
    .bad_div(bad_div), .bad_quo(bad_quo),
    .num_mag(num_mag), .den_mag(den_mag), .flip_sign(flip_sign)
  );

  assign accept      = start && !running;
  assign accept_bad  = accept && bad_div;
  assign accept_good = accept && !bad_div;

  div_restore #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept_good),
    .num_mag(num_mag), .den_mag(den_mag),
    .running(running), .final_step(final_step), .quo_next(quo_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      quotient <= '0;
      ov_wr    <= 1'b0;
      ov_val   <= 1'b0;
      so_set   <= 1'b0;
      cr0_wr   <= 1'b0;
      cond_q   <= '0;
      neg_l    <= 1'b0;
      ovf_l    <= 1'b0;
      rec_l    <= 1'b0;
    end else begin
      done   <= 1'b0;
      ov_wr  <= 1'b0;
      so_set <= 1'b0;
      cr0_wr <= 1'b0;
      if (accept_good) begin
        neg_l <= flip_sign;
        ovf_l <= ovf_en;
        rec_l <= rec_en;
      end
      if (accept_bad) begin
        done     <= 1'b1;
        quotient <= bad_quo;
        ov_wr    <= ovf_en;
        ov_val   <= 1'b1;
        so_set   <= ovf_en;
        cr0_wr   <= rec_en;
        cond_q   <= f_cond(bad_quo);
      end else if (final_step) begin
        done     <= 1'b1;
        quotient <= f_apply_sign(quo_next, neg_l);
        ov_wr    <= ovf_l;
        ov_val   <= 1'b0;
        cr0_wr   <= rec_l;
        cond_q   <= f_cond(f_apply_sign(quo_next, neg_l));
      end
    end
  end

  assign busy = running;
  assign cr0  = {cond_q.lt, cond_q.gt, cond_q.eq, so_in | so_set};

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !final_step) |=> busy);
  assert_quick_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (done && !busy));
  assert_ov_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_wr |-> done);
  assert_so_with_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
    so_set |-> (ov_wr && ov_val));
  assert_cr0_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_wr |-> ($onehot(cr0[3:1]) && done));
endmodule

// File: tb/word_divider_test.sv
module word_divider_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, signed_op = 1'b0, ovf_en = 1'b0, rec_en = 1'b0, so_in = 1'b0;
  logic [31:0] dividend = '0, divisor = 32'd1;
  logic busy, done, ov_wr, ov_val, so_set, cr0_wr;
  logic [31:0] quotient;
  logic [3:0] cr0;

  int checks = 0, errors = 0;

  word_divider #(.WIDTH(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .signed_op(signed_op), .ovf_en(ovf_en), .rec_en(rec_en), .so_in(so_in),
    .busy(busy), .done(done), .quotient(quotient), .ov_wr(ov_wr), .ov_val(ov_val),
    .so_set(so_set), .cr0_wr(cr0_wr), .cr0(cr0)
  );

  // behavioural reference state
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  logic [31:0] p_q, m_q;
  bit p_inv, p_ov, p_rec, m_inv, m_ov, m_rec;
  string p_tag, m_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [31:0] a, input logic [31:0] b, input bit s,
                                  output logic [31:0] q, output bit inv, output string tag);
    longint sa, sb;
    inv = (b == 0) || (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    if (b == 0) begin
      q = (s && a[31]) ? 32'hFFFF_FFFF : 32'h0;
      tag = "R3";
    end else if (inv) begin
      q = 32'h0;
      tag = "R4";
    end else begin
      sa = s ? longint'($signed(a)) : longint'(a);
      sb = s ? longint'($signed(b)) : longint'(b);
      q = 32'(sa / sb);
      tag = s ? "R2" : "R1";
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_q = p_q; m_inv = p_inv; m_ov = p_ov; m_rec = p_rec; m_tag = p_tag;
        end
      end else if (start) begin
        ref_div(dividend, divisor, signed_op, p_q, p_inv, p_tag);
        p_ov = ovf_en; p_rec = rec_en;
        if (p_inv) begin
          m_done = 1;
          m_q = p_q; m_inv = 1; m_ov = p_ov; m_rec = p_rec; m_tag = p_tag;
        end else begin
          m_busy = 1; m_cnt = 32;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, m_inv ? "R5" : "R1", "busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R9", "done", 32'(done), 32'(m_done));
      if (m_done) begin
        logic [3:0] ec;
        chk(quotient == m_q, m_tag, "quotient", quotient, m_q);
        chk(ov_wr == m_ov, "R6", "ov_wr", 32'(ov_wr), 32'(m_ov));
        if (m_ov) chk(ov_val == m_inv, "R6", "ov_val", 32'(ov_val), 32'(m_inv));
        chk(so_set == (m_ov && m_inv), "R7", "so_set", 32'(so_set), 32'(m_ov && m_inv));
        chk(cr0_wr == m_rec, "R8", "cr0_wr", 32'(cr0_wr), 32'(m_rec));
        ec = {m_q[31], !m_q[31] && m_q != 0, m_q == 0, so_in | (m_ov && m_inv)};
        if (m_rec) chk(cr0 == ec, "R8", "cr0", 32'(cr0), 32'(ec));
      end else begin
        chk(!ov_wr && !so_set && !cr0_wr, "R7", "idle strobes", {29'd0, ov_wr, so_set, cr0_wr}, 32'd0);
      end
    end
  end

  task automatic set_op(input logic [31:0] a, input logic [31:0] b, input bit s,
                        input bit o, input bit r, input bit so);
    dividend = a; divisor = b; signed_op = s; ovf_en = o; rec_en = r; so_in = so;
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit s,
                        input bit o, input bit r, input bit so);
    @(posedge clk); #1;
    set_op(a, b, s, o, r, so);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0 && done == 0, "R9", "reset idle", {30'd0, busy, done}, 32'd0);
    rst_n = 1'b1;
    // R1 unsigned
    run_op(32'd100, 32'd7, 0, 1, 1, 0);
    run_op(32'hFFFF_FFFF, 32'd1, 0, 0, 1, 1);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, 0);   // R2 legal unsigned
    run_op(32'd5, 32'd9, 0, 1, 1, 0);
    // R2 signed truncation
    run_op(-32'sd7, 32'd2, 1, 1, 1, 0);
    run_op(32'd7, -32'sd2, 1, 0, 1, 0);
    run_op(-32'sd7, -32'sd2, 1, 1, 1, 1);
    run_op(32'h8000_0000, 32'd1, 1, 1, 1, 0);
    // R3 zero divisor
    run_op(32'd1234, 32'd0, 0, 1, 1, 0);
    run_op(32'h9000_0000, 32'd0, 1, 1, 1, 0);
    run_op(32'h7000_0000, 32'd0, 1, 0, 1, 1);
    // R4 most negative by minus one
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 1, 0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 0, 0);
    // R9 start while busy is ignored
    @(posedge clk); #1;
    set_op(32'd1000, 32'd10, 0, 1, 1, 0);
    start = 1'b1;
    @(posedge clk); #1;
    set_op(32'd0, 32'd0, 1, 1, 1, 1);
    repeat (3) @(posedge clk);
    #1 start = 1'b0;
    while (!done) @(negedge clk);
    // R5/R9 back-to-back illegal requests each complete
    @(posedge clk); #1;
    set_op(32'hF000_0000, 32'd0, 1, 1, 1, 0);
    start = 1'b1;
    repeat (2) @(posedge clk);
    #1 start = 1'b0;
    repeat (3) @(posedge clk);
    // mixed sweep
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      case (i % 5)
        0: b = 32'd0;
        1: b = 32'hFFFF_FFFF;
        2: b = $urandom % 17;
        default: b = $urandom >> (i % 31);
      endcase
      if (i % 7 == 0) a = 32'h8000_0000;
      run_op(a, b, i[0], i[1], i[2], i[3]);
    end
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule